// File: doc/BRIEF.md
# Software-Loaded Data TLB with Tablewalk Address Assist

This block is a small, fully associative data translation buffer whose entries are installed entirely by software. Software writes an effective-page register and a segment register with the page number, address-space tag, page size and attributes, then writes the real page number. That last write installs the entry in the slot named by an index field in the control register. The index then steps on by itself, so software can fill consecutive slots without rewriting the control register. One control bit keeps the lowest four slots out of the automatic wrap.

A lookup port takes an effective address. It compares that address against all valid entries under the current address-space tag and returns a hit flag, the real page number and the page attributes in the same cycle. A lookup flagged as a real access that misses records the faulting page number in the effective-page register. During a software tablewalk, reading the table-base register returns a level-1 descriptor address. Reading the segment register returns a level-2 descriptor address. Both are built from the recorded effective page.

Top module: `swtlb_top`

## Requirements
- R1: After reset the control register reads 0x04000000 (load index 0, reserve bit clear, bit 26 set), the address-space register reads 0, and every lookup misses.
- R2: A write with select 4 (real page) installs, in the slot given by control bits 12:8, an entry with real page number = write data bits 31:12 and, from the effective-page register, page number bits 31:12 and tag bits 3:0. From the segment register it takes group bits 8:5, guarded bit 4, size bits 3:2 and write-through bit 1. The entry is valid only if effective-page bit 9 and segment bit 0 are both 1. The attribute output is {group, guarded, size, write-through}.
- R3: An entry installed by a real-page write is not seen by a lookup in the cycle of the write, and is seen from the next cycle on.
- R4: Size 2'b11 (8 MB) compares only page-number bits 19:11, size 2'b01 (512 KB) bits 19:7, and 2'b00 or 2'b10 all 20 bits. The uncompared low bits of the returned real page number come from the lookup address.
- R5: A lookup hits only entries whose tag equals the address-space register (select 5, bits 3:0).
- R6: Reading select 3 returns table-base bits 31:12, then effective-page bits 31:22 in bits 11:2, then 2'b00.
- R7: Reading select 2 returns {segment bits 31:12, 12'h000} + (effective-page bits 21:12 shifted left by 2).
- R8: After each real-page write, the index field advances by one. From 31 it wraps to 0, or to 4 when control bit 27 is set. An index of 0 to 3 written by software is still honoured.
- R9: A lookup with lk_valid high that misses loads its address bits 31:12 into effective-page bits 31:12 at the next edge, with the other bits unchanged. A register write to the effective-page register (select 1) in the same cycle takes precedence.
- R10: When several entries match, the lowest-numbered slot supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wsel | input | 3 | Write select: 0 control, 1 effective page, 2 segment, 3 table base, 4 real page, 5 address-space tag |
| reg_wdata | input | 32 | Write data |
| reg_rsel | input | 3 | Read select, same encoding |
| reg_rdata | output | 32 | Read data (combinational) |
| lk_valid | input | 1 | Lookup is a real access; a miss records the page |
| lk_ea | input | 32 | Lookup effective address |
| lk_hit | output | 1 | Translation found |
| lk_rpn | output | 20 | Real page number |
| lk_attr | output | 8 | {group[3:0], guarded, size[1:0], write-through} |

## Verification
Lookup results and register reads are combinational, so they are due in the cycle the address or select is applied. The bench drives at the falling edge and samples one nanosecond later, before the next rising edge. Register writes, entry installs, index steps and miss recording take effect at the rising edge that ends the write cycle, so their results are checked at the following sample point. The same-cycle invisibility of a new entry is checked by sampling a lookup while the install write is still pending. Every expected value comes from a model of the slot contents kept by the bench.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;

  localparam int PN_W    = 20;
  localparam int TAG_W   = 4;
  localparam int IDX_LSB = 8;
  localparam int RSV_BIT = 27;
  localparam logic [31:0] CTRL_RST = 32'h0400_0000;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_EPN   = 3'd1;
  localparam logic [2:0] SEL_SEG   = 3'd2;
  localparam logic [2:0] SEL_TBASE = 3'd3;
  localparam logic [2:0] SEL_RPN   = 3'd4;
  localparam logic [2:0] SEL_TAG   = 3'd5;

  typedef struct packed {
    logic [PN_W-1:0]  epn;
    logic [TAG_W-1:0] tag;
    logic [PN_W-1:0]  rpn;
    logic [3:0]       grp;
    logic             grd;
    logic [1:0]       psz;
    logic             wt;
  } tlb_ent_t;

  // bits of the page number that take part in the compare
  function automatic logic [PN_W-1:0] cmp_mask(input logic [1:0] psz);
    case (psz)
      2'b11:   cmp_mask = 20'hFF800;
      2'b01:   cmp_mask = 20'hFFF80;
      default: cmp_mask = 20'hFFFFF;
    endcase
  endfunction

  function automatic logic [31:0] l1_desc(input logic [31:0] tbase,
                                          input logic [31:0] epn);
    l1_desc = {tbase[31:12], epn[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] l2_desc(input logic [31:0] seg,
                                          input logic [31:0] epn);
    l2_desc = {seg[31:12], 12'h000} + {20'h0, epn[21:12], 2'b00};
  endfunction

endpackage

// File: rtl/swtlb_regs.sv
module swtlb_regs
  import swtlb_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int RSV_N = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       wsel,
  input  logic [31:0]      wdata,
  input  logic [2:0]       rsel,
  output logic [31:0]      rdata,
  input  logic             miss_rec,
  input  logic [PN_W-1:0]  miss_pn,
  output logic             commit,
  output logic [IDX_W-1:0] load_idx,
  output tlb_ent_t         new_ent,
  output logic             new_vld,
  output logic [TAG_W-1:0] cur_tag,
  output logic [PN_W-1:0]  epn_pn
);

  logic [31:0] ctrl_q, epn_q, seg_q, tbase_q;
  logic [TAG_W-1:0] tag_q;
  logic [IDX_W-1:0] idx_next;

  assign commit   = we && (wsel == SEL_RPN);
  assign load_idx = ctrl_q[IDX_LSB +: IDX_W];
  assign cur_tag  = tag_q;
  assign epn_pn   = epn_q[31:12];

  always_comb begin
    if (load_idx == IDX_W'(DEPTH - 1))
      idx_next = ctrl_q[RSV_BIT] ? IDX_W'(RSV_N) : '0;
    else
      idx_next = load_idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      tag_q  <= '0;
    end else begin
      if (we && wsel == SEL_CTRL)
        ctrl_q <= wdata;
      else if (commit)
        ctrl_q[IDX_LSB +: IDX_W] <= idx_next;
      if (we && wsel == SEL_TAG)
        tag_q <= wdata[TAG_W-1:0];
    end
  end

  // no defined reset for these
  always_ff @(posedge clk) begin
    if (we && wsel == SEL_EPN)
      epn_q <= wdata;
    else if (miss_rec)
      epn_q[31:12] <= miss_pn;
    if (we && wsel == SEL_SEG)
      seg_q <= wdata;
    if (we && wsel == SEL_TBASE)
      tbase_q <= wdata;
  end

  always_comb begin
    new_ent.epn = epn_q[31:12];
    new_ent.tag = epn_q[TAG_W-1:0];
    new_ent.rpn = wdata[31:12];
    new_ent.grp = seg_q[8:5];
    new_ent.grd = seg_q[4];
    new_ent.psz = seg_q[3:2];
    new_ent.wt  = seg_q[1];
    new_vld     = epn_q[9] & seg_q[0];
  end

  always_comb begin
    case (rsel)
      SEL_CTRL:  rdata = ctrl_q;
      SEL_EPN:   rdata = epn_q;
      SEL_SEG:   rdata = l2_desc(seg_q, epn_q);
      SEL_TBASE: rdata = l1_desc(tbase_q, epn_q);
      SEL_TAG:   rdata = {{(32-TAG_W){1'b0}}, tag_q};
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/swtlb_array.sv
module swtlb_array
  import swtlb_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [IDX_W-1:0] load_idx,
  input  tlb_ent_t         new_ent,
  input  logic             new_vld,
  input  logic [TAG_W-1:0] cur_tag,
  input  logic [PN_W-1:0]  ea_pn,
  output logic             hit,
  output logic [PN_W-1:0]  rpn,
  output logic [7:0]       attr,
  output logic [DEPTH-1:0] slot_vld,
  output logic [DEPTH-1:0] match_vec
);

  tlb_ent_t         ent [DEPTH];
  logic [IDX_W-1:0] sel;
  logic [PN_W-1:0]  msk;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    wire wr_here = commit && (load_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)       slot_vld[g] <= 1'b0;
      else if (wr_here) slot_vld[g] <= new_vld;
    end

    always_ff @(posedge clk) begin
      if (wr_here) ent[g] <= new_ent;
    end

    assign match_vec[g] = slot_vld[g] && (ent[g].tag == cur_tag) &&
                          (((ent[g].epn ^ ea_pn) & cmp_mask(ent[g].psz)) == '0);
  end

  // lowest slot wins
  always_comb begin
    sel = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (match_vec[i]) sel = IDX_W'(i);
  end

  assign hit  = |match_vec;
  assign msk  = cmp_mask(ent[sel].psz);
  assign rpn  = hit ? ((ent[sel].rpn & msk) | (ea_pn & ~msk)) : '0;
  assign attr = hit ? {ent[sel].grp, ent[sel].grd, ent[sel].psz, ent[sel].wt} : '0;

endmodule

// File: rtl/swtlb_top.sv
module swtlb_top
  import swtlb_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int RSV_N = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_wsel,
  input  logic [31:0] reg_wdata,
  input  logic [2:0]  reg_rsel,
  output logic [31:0] reg_rdata,
  input  logic        lk_valid,
  input  logic [31:0] lk_ea,
  output logic        lk_hit,
  output logic [19:0] lk_rpn,
  output logic [7:0]  lk_attr
);

  localparam int IDX_W = $clog2(DEPTH);

  logic             commit, new_vld, miss_rec;
  logic [IDX_W-1:0] load_idx;
  tlb_ent_t         new_ent;
  logic [TAG_W-1:0] cur_tag;
  logic [PN_W-1:0]  epn_pn;
  logic [DEPTH-1:0] slot_vld, match_vec;

  assign miss_rec = lk_valid && !lk_hit;

  swtlb_regs #(.DEPTH(DEPTH), .RSV_N(RSV_N)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wsel(reg_wsel), .wdata(reg_wdata),
    .rsel(reg_rsel), .rdata(reg_rdata), .miss_rec(miss_rec), .miss_pn(lk_ea[31:12]),
    .commit(commit), .load_idx(load_idx), .new_ent(new_ent), .new_vld(new_vld),
    .cur_tag(cur_tag), .epn_pn(epn_pn)
  );

  swtlb_array #(.DEPTH(DEPTH)) u_arr (
    .clk(clk), .rst_n(rst_n), .commit(commit), .load_idx(load_idx),
    .new_ent(new_ent), .new_vld(new_vld), .cur_tag(cur_tag), .ea_pn(lk_ea[31:12]),
    .hit(lk_hit), .rpn(lk_rpn), .attr(lk_attr), .slot_vld(slot_vld),
    .match_vec(match_vec)
  );

endmodule

// File: rtl/swtlb_chk.sv
module swtlb_chk
  import swtlb_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [2:0]       reg_wsel,
  input logic [2:0]       reg_rsel,
  input logic [31:0]      reg_rdata,
  input logic             lk_valid,
  input logic [31:0]      lk_ea,
  input logic             lk_hit,
  input logic [19:0]      lk_rpn,
  input logic [7:0]       lk_attr,
  input logic             commit,
  input logic             new_vld,
  input logic [IDX_W-1:0] load_idx,
  input logic [DEPTH-1:0] slot_vld,
  input logic [DEPTH-1:0] match_vec,
  input logic [PN_W-1:0]  epn_pn
);

  p_install_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit && new_vld |=> slot_vld[$past(load_idx)]);

  p_index_steps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> load_idx != $past(load_idx));

  p_miss_record_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !lk_hit && !(reg_we && reg_wsel == SEL_EPN) |=> epn_pn == $past(lk_ea[31:12]));

  p_big_page_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit && lk_attr[2:1] == 2'b11 |-> lk_rpn[10:0] == lk_ea[22:12]);

  p_l1_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rsel == SEL_TBASE |-> reg_rdata[11:0] == {epn_pn[19:10], 2'b00});

  p_l2_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rsel == SEL_SEG |-> reg_rdata[1:0] == 2'b00);

  p_hit_from_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> match_vec != '0);

  p_no_hit_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld == '0 |-> !lk_hit);

endmodule

bind swtlb_top swtlb_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wsel(reg_wsel),
  .reg_rsel(reg_rsel), .reg_rdata(reg_rdata), .lk_valid(lk_valid), .lk_ea(lk_ea),
  .lk_hit(lk_hit), .lk_rpn(lk_rpn), .lk_attr(lk_attr), .commit(commit),
  .new_vld(new_vld), .load_idx(load_idx), .slot_vld(slot_vld),
  .match_vec(match_vec), .epn_pn(epn_pn)
);

// File: tb/sim_swtlb_top.sv
module sim_swtlb_top;

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [2:0]  reg_wsel = 0, reg_rsel = 0;
  logic [31:0] reg_wdata = 0, lk_ea = 0;
  logic        lk_valid = 0;
  logic [31:0] reg_rdata;
  logic        lk_hit;
  logic [19:0] lk_rpn;
  logic [7:0]  lk_attr;

  always #2 clk = ~clk;

  swtlb_top u0 (.*);

  int nvec = 0, nbad = 0;
  bit done = 0;

  // reference model
  bit          m_v [32];
  logic [19:0] m_epn [32], m_rpn [32];
  logic [3:0]  m_tag [32];
  logic [1:0]  m_ps [32];
  logic [7:0]  m_at [32];
  logic [31:0] m_ctrl = 32'h0400_0000, m_epnr = 0, m_seg = 0, m_tb = 0;
  logic [3:0]  m_cur = 0;

  function automatic logic [19:0] ref_mask(input logic [1:0] ps);
    if (ps == 2'b11) return ~20'((1 << 11) - 1);
    if (ps == 2'b01) return ~20'((1 << 7) - 1);
    return 20'hFFFFF;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_wsel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    case (s)
      3'd0: m_ctrl = d;
      3'd1: m_epnr = d;
      3'd2: m_seg = d;
      3'd3: m_tb = d;
      3'd5: m_cur = d[3:0];
      3'd4: begin
        int k = int'(m_ctrl[12:8]);
        m_v[k] = m_epnr[9] & m_seg[0];
        m_epn[k] = m_epnr[31:12]; m_tag[k] = m_epnr[3:0];
        m_rpn[k] = d[31:12]; m_ps[k] = m_seg[3:2];
        m_at[k] = {m_seg[8:5], m_seg[4], m_seg[3:2], m_seg[1]};
        m_ctrl[12:8] = (k == 31) ? (m_ctrl[27] ? 5'd4 : 5'd0) : 5'(k + 1);
      end
      default: ;
    endcase
  endtask

  task automatic rd_chk(input logic [2:0] s, input logic [31:0] exp, input string req);
    reg_rsel = s; #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic look_chk(input logic [31:0] ea, input string req);
    bit h = 0; logic [19:0] r = 0; logic [7:0] a = 0;
    lk_ea = ea; #1;
    for (int i = 0; i < 32; i++) begin
      if (!h && m_v[i] && m_tag[i] == m_cur &&
          ((m_epn[i] & ref_mask(m_ps[i])) == (ea[31:12] & ref_mask(m_ps[i])))) begin
        h = 1;
        r = (m_rpn[i] & ref_mask(m_ps[i])) | (ea[31:12] & ~ref_mask(m_ps[i]));
        a = m_at[i];
      end
    end
    chk(lk_hit == h, req, 32'(lk_hit), 32'(h));
    if (h) begin
      chk(lk_rpn == r, req, 32'(lk_rpn), 32'(r));
      chk(lk_attr == a, req, 32'(lk_attr), 32'(a));
    end
  endtask

  // install: slot, page, tag, size, real page, group, guarded, wt, valid
  task automatic load(input int slot, input logic [19:0] pn, input logic [3:0] tg,
                      input logic [1:0] ps, input logic [19:0] rp, input logic [3:0] grp,
                      input bit g, input bit wt, input bit v, input bit rsv);
    wr(3'd0, {4'b0, rsv, 1'b1, 13'b0, 5'(slot), 8'h00});
    wr(3'd1, {pn, 2'b0, v, 5'b0, tg});
    wr(3'd2, {m_seg[31:12], 3'b0, grp, g, ps, wt, 1'b1});
    wr(3'd4, {rp, 12'h0});
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nvec++; nbad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 32; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd_chk(3'd0, 32'h0400_0000, "R1 ctrl reset");
    rd_chk(3'd5, 32'h0, "R1 tag reset");
    look_chk(32'h1234_5678, "R1 empty miss");

    // R2 basic 4K install, R5 tag mismatch
    load(5, 20'h1_0040, 4'd3, 2'b00, 20'hA_BCDE, 4'h9, 1, 1, 1, 0);
    wr(3'd5, 32'd3);
    look_chk(32'h1004_0ABC, "R2 4K hit");
    rd_chk(3'd0, 32'h0400_0600, "R8 index advanced to 6");
    wr(3'd5, 32'd2);
    look_chk(32'h1004_0ABC, "R5 tag mismatch miss");
    wr(3'd5, 32'd3);
    // invalid entry (valid bit clear) in slot 7
    load(7, 20'h2_2220, 4'd3, 2'b00, 20'h1_1111, 4'h1, 0, 0, 0, 0);
    look_chk(32'h2222_0000, "R2 invalid entry misses");

    // R4 sizes
    load(8, 20'h4_0000, 4'd3, 2'b11, 20'h8_0000, 4'h2, 0, 0, 1, 0);
    look_chk(32'h4076_5432, "R4 8MB offset pass-through");
    look_chk(32'h4080_0000, "R4 8MB beyond page miss");
    load(9, 20'h6_0000, 4'd3, 2'b01, 20'h3_0000, 4'h3, 1, 0, 1, 0);
    look_chk(32'h6007_F000, "R4 512KB last page");
    look_chk(32'h6008_0000, "R4 512KB next miss");
    load(10, 20'h7_0000, 4'd3, 2'b10, 20'h5_5555, 4'h4, 0, 1, 1, 0);
    look_chk(32'h7000_0FFF, "R4 size 10 exact");
    look_chk(32'h7000_1000, "R4 size 10 neighbour miss");

    // R3 same-cycle invisibility
    wr(3'd0, 32'h0400_0B00);
    wr(3'd1, 32'h5550_0203);
    wr(3'd2, 32'h0000_0001);
    @(negedge clk);
    reg_we = 1; reg_wsel = 3'd4; reg_wdata = 32'h1212_1000; lk_ea = 32'h5550_0000; #1;
    chk(lk_hit == 1'b0, "R3 not visible in write cycle", 32'(lk_hit), 32'h0);
    @(negedge clk);
    reg_we = 0;
    m_v[11] = 1; m_epn[11] = 20'h5_5500; m_tag[11] = 3; m_rpn[11] = 20'h1_2121;
    m_ps[11] = 0; m_at[11] = 0; m_ctrl[12:8] = 5'd12;
    look_chk(32'h5550_0000, "R3 visible next cycle");

    // R8 wrap with and without reserve
    load(31, 20'h9_0000, 4'd3, 2'b00, 20'h9_0001, 4'h0, 0, 0, 1, 0);
    rd_chk(3'd0, 32'h0400_0000, "R8 wrap to 0");
    load(31, 20'h9_1000, 4'd3, 2'b00, 20'h9_1001, 4'h0, 0, 0, 1, 1);
    rd_chk(3'd0, 32'h0C00_0400, "R8 reserve wrap to 4");
    load(2, 20'h9_2000, 4'd3, 2'b00, 20'h9_2002, 4'h5, 0, 0, 1, 1);
    look_chk(32'h9200_0000, "R8 explicit reserved slot 2");
    rd_chk(3'd0, 32'h0C00_0300, "R8 explicit index steps to 3");

    // R10 priority
    load(20, 20'hB_0000, 4'd3, 2'b00, 20'h0_0020, 4'h6, 0, 0, 1, 0);
    load(13, 20'hB_0000, 4'd3, 2'b11, 20'h0_0800, 4'h7, 0, 0, 1, 0);
    look_chk(32'hB000_0000, "R10 lower slot wins");

    // R9 miss recording
    wr(3'd1, 32'h0000_0A5C);
    @(negedge clk);
    lk_valid = 1; lk_ea = 32'hDEAD_B123;
    @(negedge clk);
    lk_valid = 0; m_epnr = 32'hDEAD_BA5C;
    rd_chk(3'd1, 32'hDEAD_BA5C, "R9 miss recorded");
    @(negedge clk);
    lk_valid = 1; lk_ea = 32'hFEED_F000;
    reg_we = 1; reg_wsel = 3'd1; reg_wdata = 32'h1357_9000;
    @(negedge clk);
    lk_valid = 0; reg_we = 0; m_epnr = 32'h1357_9000;
    rd_chk(3'd1, 32'h1357_9000, "R9 register write wins");
    @(negedge clk);
    lk_valid = 1; lk_ea = 32'h5550_0777;
    @(negedge clk);
    lk_valid = 0;
    rd_chk(3'd1, 32'h1357_9000, "R9 hit leaves register");

    // R6 R7 random descriptor addresses
    for (int n = 0; n < 40; n++) begin
      logic [31:0] e = $urandom, t = $urandom, s = $urandom;
      wr(3'd1, e); wr(3'd3, t); wr(3'd2, s);
      rd_chk(3'd3, {t[31:12], e[31:22], 2'b00}, "R6 level-1 address");
      rd_chk(3'd2, {s[31:12], 12'h0} + 32'(e[21:12]) * 4, "R7 level-2 address");
    end

    // random installs and lookups
    for (int n = 0; n < 150; n++) begin
      int sl = int'($urandom_range(4, 31));
      logic [1:0] ps = 2'($urandom);
      logic [19:0] pn = {4'($urandom_range(0, 3)), 16'($urandom)};
      load(sl, pn, 4'($urandom_range(2, 3)), ps, 20'($urandom), 4'($urandom),
           1'($urandom), 1'($urandom), ($urandom_range(0, 7) != 0), 0);
      if ($urandom_range(0, 3) == 0) wr(3'd5, 32'($urandom_range(2, 3)));
      for (int q = 0; q < 3; q++) begin
        int p = int'($urandom_range(4, 31));
        logic [19:0] near = m_epn[p] ^ (20'($urandom) & 20'h007FF & ~20'($urandom));
        look_chk({near, 12'($urandom)}, "R4 R5 R10 random lookup");
      end
    end

    finish_run();
  end

endmodule